// File: doc/BRIEF.md
# Opcode-mapped bit I/O unit

This unit sits on the instruction path between memory and an 8-bit CPU that marks each opcode fetch with a strobe. While the strobe is high it looks at the byte coming from memory. A small set of otherwise unused opcode patterns is claimed for bit-level I/O. A claimed byte never reaches the CPU. The unit puts a replacement opcode on the CPU bus in its place, and the program sees only ordinary instructions.

The unit serves two kinds of I/O. A set/clear byte writes one bit of an eight-bit addressable output latch and hands the CPU a NOP. A probe byte takes one of eight synchronized input pins, inverts it if the byte asks for that, and hands the CPU one of two conditional-branch opcodes. The branch then follows the pin level. The branch offset that follows in memory is fetched without the strobe and passes through unchanged. Every unclaimed byte, and every cycle without the strobe, is forwarded from memory to the CPU as it is.

Top module: `opbit_io_unit`

## Requirements
- R1: With fetch_i low, cpu_data_o equals mem_data_i for every byte value, and latch_o does not change.
- R2: With fetch_i high, any byte with bit 7 set, or with bits [1:0] not equal to 2'b11, is forwarded unchanged to cpu_data_o.
- R3: With fetch_i high and a byte of the form 0nnn1d11 (bit 7 = 0, bit 3 = 1, bits [1:0] = 11), cpu_data_o is 8'hEA in that same cycle.
- R4: A set/clear fetch writes bit n (byte bits [6:4]) of latch_o to d (byte bit 2) at the rising clock edge that ends the fetch cycle. The other seven bits keep their values.
- R5: With fetch_i high and a byte of the form 0nnn0d11 (bit 3 = 0), cpu_data_o is 8'h50 when synchronized input n XOR d is 0, and 8'h70 when it is 1.
- R6: Each of the pins_i inputs passes through a two-flop synchronizer. A probe reflects a pin change only after two rising edges have occurred since the change, and not after just one.
- R7: After the asynchronous active-low reset, latch_o is 8'h00 and every synchronized input reads 0. This holds even when pins_i is high while reset is asserted.
- R8: A probe fetch leaves latch_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one cycle per CPU bus cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_i | input | 1 | Opcode-fetch strobe from the CPU |
| mem_data_i | input | 8 | Byte read from memory |
| cpu_data_o | output | 8 | Byte presented to the CPU |
| pins_i | input | 8 | Asynchronous input pins |
| latch_o | output | 8 | Addressable output latch |

## Verification
Two events can fall in the same cycle: a pin edge reaching the synchronizer, and a probe fetch that reads that pin. The bench provokes this by changing a pin at the falling edge of the cycle in which it fetches a probe for that pin. It then repeats the probe over the next two cycles. The result is judged correct only if the branch opcode keeps the old sense for exactly two probes and flips on the third. Latch writes and branch substitution are also interleaved across full byte sweeps, and the latch is compared after every edge.

// File: rtl/opbit_pkg.sv
package opbit_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = 3;
  localparam int unsigned N_BITS = 1 << IDX_W;

  localparam logic [BYTE_W-1:0] OPC_NOP    = 8'hEA;
  localparam logic [BYTE_W-1:0] OPC_BR_CLR = 8'h50;
  localparam logic [BYTE_W-1:0] OPC_BR_SET = 8'h70;

  typedef struct packed {
    logic             wr;
    logic             tst;
    logic [IDX_W-1:0] idx;
    logic             val;
  } op_dec_t;
endpackage

// File: rtl/opbit_decoder.sv
module opbit_decoder
  import opbit_pkg::*;
(
  input  logic              fetch_i,
  input  logic [BYTE_W-1:0] byte_i,
  output op_dec_t           dec_o
);
  logic claim;

  // claimed space: 0xxx_xx11 during a strobed fetch
  assign claim     = fetch_i && !byte_i[7] && (byte_i[1:0] == 2'b11);
  assign dec_o.wr  = claim &&  byte_i[3];
  assign dec_o.tst = claim && !byte_i[3];
  assign dec_o.idx = byte_i[4 +: IDX_W];
  assign dec_o.val = byte_i[2];
endmodule

// File: rtl/opbit_sync.sv
module opbit_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain[0] <= '0;
    else         chain[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[s] <= '0;
      else         chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/opbit_latch.sv
module opbit_latch
  import opbit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              val_i,
  output logic [N_BITS-1:0] q_o
);
  for (genvar b = 0; b < N_BITS; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            q_o[b] <= 1'b0;
      else if (wr_i && idx_i == IDX_W'(b))    q_o[b] <= val_i;
    end
  end

  a_r4_bit_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> q_o[$past(idx_i)] == $past(val_i));

  a_r1_held_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_o));
endmodule

// File: rtl/opbit_io_unit.sv
module opbit_io_unit
  import opbit_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_i,
  input  logic [BYTE_W-1:0] mem_data_i,
  output logic [BYTE_W-1:0] cpu_data_o,
  input  logic [N_BITS-1:0] pins_i,
  output logic [N_BITS-1:0] latch_o
);
  op_dec_t           dec;
  logic [N_BITS-1:0] pins_s;
  logic              taken;

  opbit_decoder i_dec (
    .fetch_i (fetch_i),
    .byte_i  (mem_data_i),
    .dec_o   (dec)
  );

  opbit_sync #(.WIDTH(N_BITS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_i),
    .q_o    (pins_s)
  );

  opbit_latch i_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (dec.wr),
    .idx_i  (dec.idx),
    .val_i  (dec.val),
    .q_o    (latch_o)
  );

  assign taken = pins_s[dec.idx] ^ dec.val;

  always_comb begin
    if (dec.wr)       cpu_data_o = OPC_NOP;
    else if (dec.tst) cpu_data_o = taken ? OPC_BR_SET : OPC_BR_CLR;
    else              cpu_data_o = mem_data_i;
  end

  a_r1_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_i |-> cpu_data_o == mem_data_i);

  a_r3_nop_fed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_i && mem_data_i[7] == 1'b0 && mem_data_i[3:0] == 4'b1011)
      |-> cpu_data_o == OPC_NOP);

  a_r5_branch_fed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_i && mem_data_i[7] == 1'b0 && mem_data_i[3] == 1'b0 && mem_data_i[1:0] == 2'b11)
      |-> (cpu_data_o == OPC_BR_CLR || cpu_data_o == OPC_BR_SET));

  a_r8_probe_keeps_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_i && mem_data_i[7] == 1'b0 && mem_data_i[3] == 1'b0 && mem_data_i[1:0] == 2'b11)
      |=> $stable(latch_o));
endmodule

// File: tb/test_opbit_io_unit.sv
module test_opbit_io_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fetch_i = 1'b0;
  logic [7:0] mem_data_i = 8'h00;
  logic [7:0] pins_i = 8'h00;
  logic [7:0] cpu_data_o;
  logic [7:0] latch_o;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  logic [7:0] model_latch = 8'h00;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  opbit_io_unit i_opbit_io_unit (
    .clk_i, .rst_ni, .fetch_i, .mem_data_i, .cpu_data_o, .pins_i, .latch_o
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_cpu(input logic f, input logic [7:0] b, input logic [7:0] p);
    if (f && !b[7] && b[1:0] == 2'b11) begin
      if (b[3]) return 8'hEA;
      return (p[b[6:4]] ^ b[2]) ? 8'h70 : 8'h50;
    end
    return b;
  endfunction

  function automatic string tag(input logic f, input logic [7:0] b);
    if (!f) return "R1";
    if (b[7] || b[1:0] != 2'b11) return "R2";
    return b[3] ? "R3" : "R5";
  endfunction

  // one bus cycle: drive at negedge, check output mid-cycle, check latch after edge
  task automatic cycle(input logic f, input logic [7:0] b, input logic [7:0] p_sync);
    @(negedge clk_i);
    fetch_i = f;
    mem_data_i = b;
    #1;
    check8(tag(f, b), cpu_data_o, exp_cpu(f, b, p_sync));
    @(posedge clk_i);
    #1;
    if (f && !b[7] && b[1:0] == 2'b11 && b[3]) model_latch[b[6:4]] = b[2];
    check8((f && !b[7] && b[1:0] == 2'b11) ? (b[3] ? "R4" : "R8") : "R1", latch_o, model_latch);
  endtask

  task automatic probe(input string req, input logic [7:0] b, input logic [7:0] exp);
    @(negedge clk_i);
    fetch_i = 1'b1;
    mem_data_i = b;
    #1;
    check8(req, cpu_data_o, exp);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
    // R7: pins high through reset, synchronizer must still read zero
    pins_i = 8'hFF;
    #9;
    check8("R7", latch_o, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    fetch_i = 1'b1;
    mem_data_i = 8'h33;
    #1;
    check8("R7", cpu_data_o, 8'h50);
    check8("R7", latch_o, 8'h00);
    @(negedge clk_i);
    fetch_i = 1'b0;

    // sweeps across input patterns
    foreach (pats[k]) begin
      pins_i = pats[k];
      for (int i = 0; i < 3; i++) cycle(1'b0, 8'h00, pats[k]);
      for (int b = 0; b < 256; b++) cycle(1'b1, 8'(b), pats[k]);
      for (int b = 0; b < 256; b++) cycle(1'b0, 8'(b), pats[k]);
      for (int b = 255; b >= 0; b--) cycle(1'b1, 8'(b), pats[k]);
    end

    // R6: pin edge in the same cycle as a probe of that pin
    pins_i = 8'h00;
    for (int i = 0; i < 3; i++) cycle(1'b0, 8'h00, 8'h00);
    @(negedge clk_i);
    pins_i[3] = 1'b1;
    fetch_i = 1'b1;
    mem_data_i = 8'h33;
    #1;
    check8("R6", cpu_data_o, 8'h50);
    probe("R6", 8'h33, 8'h50);
    probe("R6", 8'h33, 8'h70);
    probe("R6", 8'h37, 8'h50);
    @(negedge clk_i);
    pins_i[3] = 1'b0;
    #1;
    check8("R6", cpu_data_o, 8'h50);
    probe("R6", 8'h37, 8'h50);
    probe("R6", 8'h37, 8'h70);

    // R4: walk every latch bit set then clear, checking neighbours held
    for (int n = 0; n < 8; n++) cycle(1'b1, {1'b0, 3'(n), 4'b1111}, 8'h00);
    for (int n = 0; n < 8; n += 2) cycle(1'b1, {1'b0, 3'(n), 4'b1011}, 8'h00);
    check8("R4", latch_o, 8'hAA);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule